// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Registers

This block drives and samples 32 general-purpose pins arranged as two banks of 16: a low bank for pins 0–15 and a high bank for pins 16–31. Each bank holds eight per-pin feature registers: output level, drive enable, open-drain mode, pull-up request, pull-down request, input enable, input inversion and output inversion. There is also one read-only register that holds the synchronized input level of each pin. A pin's behaviour is the combination of these bits. It can be a plain input, a push-pull output, an open-drain output, a tristated pin, or a pin with a pull request, and either direction can be inverted.

Every write uses a set/clear format, so software can change one pin without first reading the register. In a 32-bit write, bit n sets the pin's feature bit and bit n+16 clears it. If both bits are 1 for the same pin, the clear wins. The high bank sits at a fixed offset of 0x80 above the low bank. Within a bank, pin n of the high bank is pin 16+n of the chip.

The pad side has four outputs. Two are the drive level and the drive enable, both computed from the registers. The other two export the pull requests to the pad ring as they are.

Top module: `gpsc_top`

## Requirements
- R1: While rst_n is low, and after it, until the first write, all feature registers read 0. pad_oe, pad_out, pad_pu and pad_pd are all 0, and rdata is 0.
- R2: A write to a feature register sets pin n's bit when wdata bit n is 1 and wdata bit n+16 is 0. Pins whose two bits are both 0 keep their value.
- R3: A write clears pin n's bit when wdata bit n+16 is 1.
- R4: When wdata bits n and n+16 are both 1, pin n's bit ends at 0.
- R5: Register offsets within a bank are: output level 0x00, drive enable 0x04, open-drain 0x08, pull-up 0x0C, pull-down 0x10, input enable 0x14, input invert 0x18, output invert 0x1C, input status 0x20 (read only). The high bank uses the same offsets plus 0x80, and its bit n controls chip pin 16+n.
- R6: When rd_en is high at a clock edge, rdata takes the addressed bank's 16 bits in rdata[15:0], with rdata[31:16] at 0. rdata holds that value until the next read. A read in the same cycle as a write to the same register returns the value from before the write.
- R7: pad_out[p] equals output level XOR output invert for pin p.
- R8: pad_oe[p] equals drive enable AND NOT (open-drain AND pad_out[p]). An open-drain pin therefore drives only a low level.
- R9: pad_pu and pad_pd reflect the pull-up and pull-down registers bit for bit.
- R10: The input status bit of pin p is (pad_in[p] XOR input invert) AND input enable. It passes through two flops, so a change on pad_in reaches the status register two clock edges later.
- R11: Writes are ignored when the address is misaligned (addr[1:0] not 0), lies past 0x20 within a bank, or targets the input status register. Reads of unmapped addresses return 0.
- R12: A write changes only the addressed register of the addressed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe; rdata updates at the same edge |
| addr | input | 8 | Byte address; bit 7 selects the bank |
| wdata | input | 32 | Set bits in [15:0], clear bits in [31:16] |
| rdata | output | 32 | Registered read data, bank bits in [15:0] |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad drive level after output inversion |
| pad_oe | output | 32 | Pad drive enable |
| pad_pu | output | 32 | Pull-up requests |
| pad_pd | output | 32 | Pull-down requests |

## Verification
Two collisions can happen in a single cycle.

The first is inside one write: a set and a clear can hit the same pin. The stimulus table includes words where both halves have the same bit high, including an all-ones word. Each is judged by reading the register back and expecting 0 for every colliding pin.

The second is a read and a write to the same register on the same edge. The bench issues both strobes together and expects the earlier value first. A separate read that follows must then return the updated value.

// File: rtl/gpsc_pkg.sv
package gpsc_pkg;
  localparam int FEAT_N = 8;
  typedef enum logic [3:0] {
    F_OUT    = 4'd0,
    F_OE     = 4'd1,
    F_OD     = 4'd2,
    F_PU     = 4'd3,
    F_PD     = 4'd4,
    F_IE     = 4'd5,
    F_IINV   = 4'd6,
    F_OINV   = 4'd7,
    F_INSTAT = 4'd8
  } reg_id_e;
endpackage

// File: rtl/gpsc_decode.sv
module gpsc_decode
  import gpsc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int STRIDE_W = 7,
  parameter int NBANK    = 2,
  parameter int BIDX_W   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BIDX_W-1:0] bank_idx,
  output logic [FEAT_N-1:0] reg_sel,
  output logic              stat_sel
);
  localparam int BF_W = ADDR_W - STRIDE_W;
  localparam int WD_W = STRIDE_W - 2;

  logic [BF_W-1:0] bank_f;
  logic [WD_W-1:0] word;
  logic            aligned;
  logic            bank_ok;

  assign bank_f   = addr[ADDR_W-1:STRIDE_W];
  assign word     = addr[STRIDE_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign bank_ok  = (int'(bank_f) < NBANK);
  assign bank_idx = BIDX_W'(bank_f);

  always_comb begin
    reg_sel  = '0;
    stat_sel = 1'b0;
    if (aligned && bank_ok) begin
      for (int f = 0; f < FEAT_N; f++) begin
        if (int'(word) == f) reg_sel[f] = 1'b1;
      end
      if (int'(word) == int'(F_INSTAT)) stat_sel = 1'b1;
    end
  end
endmodule

// File: rtl/gpsc_bank.sv
module gpsc_bank
  import gpsc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [FEAT_N-1:0]          wr_sel,
  input  logic [W-1:0]               set_bits,
  input  logic [W-1:0]               clr_bits,
  output logic [FEAT_N-1:0][W-1:0]   feat_q
);
  for (genvar f = 0; f < FEAT_N; f++) begin : g_feat
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (wr_sel[f]) q <= (q | set_bits) & ~clr_bits;
    end
    assign feat_q[f] = q;
  end
endmodule

// File: rtl/gpsc_pad.sv
module gpsc_pad #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] out_v,
  input  logic [W-1:0] oe,
  input  logic [W-1:0] od,
  input  logic [W-1:0] ie,
  input  logic [W-1:0] iinv,
  input  logic [W-1:0] oinv,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] in_sync
);
  logic [W-1:0] eff;
  logic [W-1:0] in_raw;
  logic [W-1:0] s1;

  assign eff     = out_v ^ oinv;
  assign pad_out = eff;
  assign pad_oe  = oe & ~(od & eff);
  assign in_raw  = (pad_in ^ iinv) & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= '0;
      in_sync <= '0;
    end else begin
      s1      <= in_raw;
      in_sync <= s1;
    end
  end
endmodule

// File: rtl/gpsc_top.sv
module gpsc_top
  import gpsc_pkg::*;
#(
  parameter int BANK_W   = 16,
  parameter int NBANK    = 2,
  parameter int ADDR_W   = 8,
  parameter int STRIDE_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*BANK_W-1:0]   wdata,
  output logic [2*BANK_W-1:0]   rdata,
  input  logic [BANK_W*NBANK-1:0] pad_in,
  output logic [BANK_W*NBANK-1:0] pad_out,
  output logic [BANK_W*NBANK-1:0] pad_oe,
  output logic [BANK_W*NBANK-1:0] pad_pu,
  output logic [BANK_W*NBANK-1:0] pad_pd
);
  localparam int NPINS  = BANK_W * NBANK;
  localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [BIDX_W-1:0]             bank_idx;
  logic [FEAT_N-1:0]             reg_sel;
  logic                          stat_sel;
  logic [FEAT_N-1:0][NPINS-1:0]  feat_all;
  logic [NPINS-1:0]              in_vec;
  logic [NPINS-1:0]              out_vec;
  logic [NPINS-1:0]              od_vec;
  logic [BANK_W-1:0]             rd_val;

  gpsc_decode #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .NBANK(NBANK), .BIDX_W(BIDX_W)
  ) u_dec (
    .addr(addr), .bank_idx(bank_idx), .reg_sel(reg_sel), .stat_sel(stat_sel)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [FEAT_N-1:0]             wsel;
    logic [FEAT_N-1:0][BANK_W-1:0] bq;

    assign wsel = (wr_en && (int'(bank_idx) == b)) ? reg_sel : '0;

    gpsc_bank #(.W(BANK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_sel(wsel),
      .set_bits(wdata[BANK_W-1:0]), .clr_bits(wdata[2*BANK_W-1:BANK_W]),
      .feat_q(bq)
    );

    for (genvar f = 0; f < FEAT_N; f++) begin : g_map
      assign feat_all[f][b*BANK_W +: BANK_W] = bq[f];
    end

    gpsc_pad #(.W(BANK_W)) u_pad (
      .clk(clk), .rst_n(rst_n),
      .out_v(bq[F_OUT]), .oe(bq[F_OE]), .od(bq[F_OD]),
      .ie(bq[F_IE]), .iinv(bq[F_IINV]), .oinv(bq[F_OINV]),
      .pad_in(pad_in[b*BANK_W +: BANK_W]),
      .pad_out(pad_out[b*BANK_W +: BANK_W]),
      .pad_oe(pad_oe[b*BANK_W +: BANK_W]),
      .in_sync(in_vec[b*BANK_W +: BANK_W])
    );
  end

  assign pad_pu  = feat_all[F_PU];
  assign pad_pd  = feat_all[F_PD];
  assign out_vec = feat_all[F_OUT];
  assign od_vec  = feat_all[F_OD];

  always_comb begin
    rd_val = '0;
    for (int f = 0; f < FEAT_N; f++) begin
      if (reg_sel[f]) rd_val = feat_all[f][int'(bank_idx)*BANK_W +: BANK_W];
    end
    if (stat_sel) rd_val = in_vec[int'(bank_idx)*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= {{BANK_W{1'b0}}, rd_val};
  end
endmodule

// File: rtl/gpsc_chk.sv
module gpsc_chk #(
  parameter int BANK_W = 16,
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [2*BANK_W-1:0] wdata,
  input logic [2*BANK_W-1:0] rdata,
  input logic [NPINS-1:0]    pad_out,
  input logic [NPINS-1:0]    pad_oe,
  input logic [NPINS-1:0]    out_vec,
  input logic [NPINS-1:0]    od_vec
);
  logic lo_out_wr;
  assign lo_out_wr = wr_en && (addr == '0);

  // R1: reset holds the pads undriven and the read port quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && rdata == '0));

  // R2: set bits without a matching clear land in the register
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    lo_out_wr |=> ((out_vec[BANK_W-1:0] & $past(wdata[BANK_W-1:0] & ~wdata[2*BANK_W-1:BANK_W]))
                   == $past(wdata[BANK_W-1:0] & ~wdata[2*BANK_W-1:BANK_W])));

  // R3 and R4: any pin with its clear bit high ends at 0, set or not
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lo_out_wr |=> ((out_vec[BANK_W-1:0] & $past(wdata[2*BANK_W-1:BANK_W])) == '0));

  // R6: upper half of read data is always 0
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[2*BANK_W-1:BANK_W] == '0);

  // R8: an open-drain pin never drives a high level
  a_r8_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & od_vec) == '0);

  // R11: without a write strobe the output-level register does not move
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_vec));
endmodule

bind gpsc_top gpsc_chk #(
  .BANK_W(BANK_W), .NPINS(BANK_W*NBANK), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .out_vec(out_vec), .od_vec(od_vec)
);

// File: tb/sim_gpsc_top.sv
`timescale 1ns/1ps
module sim_gpsc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpsc_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // {write addr, write data, read addr, expected read data}
  localparam int NV = 12;
  localparam logic [79:0] VEC [NV] = '{
    {8'h00, 32'h0000_0005, 8'h00, 32'h0000_0005}, // R2 set two pins
    {8'h00, 32'h0001_0002, 8'h00, 32'h0000_0006}, // R3 clear pin0, set pin1
    {8'h00, 32'h0004_0004, 8'h00, 32'h0000_0002}, // R4 set+clear same pin
    {8'h80, 32'h0000_8001, 8'h80, 32'h0000_8001}, // R5 high bank level
    {8'h84, 32'h0000_00FF, 8'h04, 32'h0000_0000}, // R12 low drive enable untouched
    {8'h04, 32'h0000_000F, 8'h04, 32'h0000_000F}, // R5 low drive enable
    {8'h24, 32'h0000_FFFF, 8'h24, 32'h0000_0000}, // R11 past last register
    {8'h20, 32'h0000_FFFF, 8'h20, 32'h0000_0000}, // R11 status is read only
    {8'h01, 32'h0000_FFFF, 8'h00, 32'h0000_0002}, // R11 misaligned write
    {8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000}, // R4 all collide
    {8'hA4, 32'h0000_0001, 8'h84, 32'h0000_00FF}, // R11 high bank unmapped
    {8'h9C, 32'h0000_8000, 8'h9C, 32'h0000_8000}  // R5 high output invert
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_pu", pad_pu, 32'h0);
    check("R1 pad_pd", pad_pd, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    rst_n = 1'b1;
    rd(8'h00, r);
    check("R1 level reg after reset", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], r);
      check($sformatf("table entry %0d (R2..R12 per row)", i), r, VEC[i][31:0]);
    end

    // R7 / R8 drive generation
    wr(8'h00, 32'hFFFF_0000);
    wr(8'h00, 32'h0000_0003);
    wr(8'h1C, 32'h0000_0002);
    check("R7 pad_out", pad_out, 32'h0001_0001);
    wr(8'h08, 32'h0000_0003);
    check("R8 pad_oe open-drain", pad_oe, 32'h00FF_000E);
    check("R7 pad_out with open-drain", pad_out, 32'h0001_0001);

    // R9 pull exports
    wr(8'h8C, 32'h0000_0100);
    wr(8'h10, 32'h0000_0010);
    check("R9 pad_pu", pad_pu, 32'h0100_0000);
    check("R9 pad_pd", pad_pd, 32'h0000_0010);

    // R10 input path
    wr(8'h14, 32'h0000_00FF);
    wr(8'h18, 32'h0000_000F);
    @(negedge clk);
    pad_in = 32'hFFFF_0033;
    repeat (3) @(negedge clk);
    rd(8'h20, r);
    check("R10 low status", r, 32'h0000_003C);
    rd(8'hA0, r);
    check("R10 high bank input disabled", r, 32'h0);
    // change pad and read in the same cycle: old value still in the second flop
    @(negedge clk);
    pad_in = 32'h0;
    rd_en = 1'b1; addr = 8'h20;
    @(negedge clk);
    rd_en = 1'b0;
    check("R10 two-flop latency", rdata, 32'h0000_003C);
    repeat (2) @(negedge clk);
    rd(8'h20, r);
    check("R10 settled status", r, 32'h0000_000F);

    // R6 read during write returns the old value, then rdata holds
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'h00; wdata = 32'h0000_0008;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R6 read during write", rdata, 32'h0000_0003);
    @(negedge clk);
    check("R6 rdata holds", rdata, 32'h0000_0003);
    rd(8'h00, r);
    check("R6 value after write", r, 32'h0000_000B);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule